// File: doc/BRIEF.md
# Serial Command Receiver for a Three-Channel LED Controller

This block is a receive-only I2C target that turns bus writes into register load pulses. SCL and SDA are brought into the system clock domain and oversampled. START and STOP conditions are found from the sampled lines. The first byte of a frame must carry the fixed device address with a write direction bit. The block acknowledges that byte by pulling SDA low. After that, every byte in the frame is a command, and each one is acknowledged in the same way.

A command byte splits into two fields. The upper three bits pick one of eight target registers: shutdown, peak current step, the three channel duty values, the rising dimming target, the falling dimming target, and the dimming step time with run. The lower five bits are the value. When a command byte is acknowledged, the block raises a one-cycle write enable for the selected register, with the value presented alongside it. The surrounding register file loads on that pulse. Several commands may follow one address before the STOP.

Top module: `i2c_cmd_decoder`

## Requirements
- R1: After reset, `sda_pull_o` is 0 and every bit of `wr_en_o` is 0.
- R2: A first byte of 0x72 (address 0x39, direction bit 0) is acknowledged: `sda_pull_o` is 1 while SCL is high in the ninth clock of that byte, and it rises only while SCL is low.
- R3: A first byte with another address, or with direction bit 1 (for example 0x73), is not acknowledged. All following bytes up to the next START get no acknowledge and no write enable.
- R4: In an addressed frame, every command byte is acknowledged during its ninth clock, and any write enable occurs while that acknowledge is held.
- R5: A command byte raises exactly one write enable, `wr_en_o[k]`, where k is the value of bits 7:5. The codes are 0 shutdown, 1 peak current, 2/3/4 channel 1/2/3 duty, 5 rising target, 6 falling target, and 7 step time with run. `wr_data_o` then carries bits 4:0.
- R6: For select code 0 (shutdown), `wr_data_o` is 0 whatever bits 4:0 hold.
- R7: Each acknowledged command byte produces one write enable pulse lasting exactly one clock cycle. The pulse follows the rising SCL edge of the ninth clock.
- R8: Several command bytes after one address in the same frame each produce their own write enable, in order.
- R9: A STOP that arrives partway through a command byte discards the partial byte and produces no write enable. A later frame is received normally.
- R10: A repeated START partway through a command byte discards the partial byte and produces no write enable. The byte after the START is treated as a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| sda_pull_o | output | 1 | 1 drives the data line low (acknowledge) |
| wr_en_o | output | 8 | One-hot write enable, one bit per target register |
| wr_data_o | output | 5 | Value for the enabled register |

## Verification
The main decode is driven with random command bytes that span all eight select codes and arbitrary values, in frames of one to three commands. This separates a wrong select mapping from a wrong value field and shows whether back-to-back commands keep their order. Directed frames use the wrong address and the read bit, to confirm that the block stays silent up to the next START. Shutdown bytes carry nonzero low bits, so that a leak of those bits into the value can be seen. Truncated bytes are cut off by either a STOP or a repeated START, to show that both abort paths drop the partial byte and that the receiver recovers for the frame that follows.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;

    localparam int SEL_W  = 3;
    localparam int DATA_W = 5;
    localparam int CMD_W  = SEL_W + DATA_W;
    localparam int NUM_FUNC = 1 << SEL_W;
    localparam int CNT_W  = $clog2(CMD_W + 1);

    localparam logic [SEL_W-1:0] FN_SHUTDOWN = 3'd0;
    localparam logic [SEL_W-1:0] FN_PEAK     = 3'd1;
    localparam logic [SEL_W-1:0] FN_DUTY1    = 3'd2;
    localparam logic [SEL_W-1:0] FN_DUTY2    = 3'd3;
    localparam logic [SEL_W-1:0] FN_DUTY3    = 3'd4;
    localparam logic [SEL_W-1:0] FN_RISE_TGT = 3'd5;
    localparam logic [SEL_W-1:0] FN_FALL_TGT = 3'd6;
    localparam logic [SEL_W-1:0] FN_STEP_RUN = 3'd7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } link_st_e;

    typedef struct packed {
        link_st_e         st;
        logic [CNT_W-1:0] bitcnt;
        logic [CMD_W-1:0] shreg;
        logic [CMD_W-1:0] cmd;
        logic             ack;
        logic             fire;
    } link_state_t;

    typedef struct packed {
        logic scl_prev;
        logic sda_prev;
    } cond_state_t;

endpackage

// File: rtl/cmdrx_sync.sv
module cmdrx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/cmdrx_cond.sv
module cmdrx_cond
    import cmdrx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    cond_state_t cond_d, cond_q;

    always_comb begin
        cond_d.scl_prev = scl_s;
        cond_d.sda_prev = sda_s;
        // data edges while the clock stays high mark frame boundaries
        start_o = scl_s &  cond_q.scl_prev &  cond_q.sda_prev & ~sda_s;
        stop_o  = scl_s &  cond_q.scl_prev & ~cond_q.sda_prev &  sda_s;
        rise_o  = scl_s & ~cond_q.scl_prev;
        fall_o  = ~scl_s & cond_q.scl_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cond_q <= '{scl_prev: 1'b1, sda_prev: 1'b1};
        else        cond_q <= cond_d;
    end

endmodule

// File: rtl/cmdrx_link.sv
module cmdrx_link
    import cmdrx_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h39
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             sda_s,
    output logic             ack_o,
    output logic             fire_o,
    output logic [CMD_W-1:0] cmd_o
);

    localparam logic [CMD_W-1:0] ADDR_WORD = {DEV_ADDR, 1'b0};
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(CMD_W);

    link_state_t link_d, link_q;

    always_comb begin
        link_d      = link_q;
        link_d.fire = 1'b0;
        if (start_i) begin
            link_d.st     = ST_ADDR;
            link_d.bitcnt = '0;
            link_d.shreg  = '0;
            link_d.ack    = 1'b0;
        end else if (stop_i) begin
            link_d.st     = ST_IDLE;
            link_d.bitcnt = '0;
            link_d.ack    = 1'b0;
        end else begin
            case (link_q.st)
                ST_ADDR, ST_DATA: begin
                    if (rise_i && link_q.bitcnt < FULL_CNT) begin
                        link_d.shreg  = {link_q.shreg[CMD_W-2:0], sda_s};
                        link_d.bitcnt = link_q.bitcnt + 1'b1;
                    end else if (fall_i && link_q.bitcnt == FULL_CNT) begin
                        if (link_q.st == ST_ADDR) begin
                            if (link_q.shreg == ADDR_WORD) begin
                                link_d.st  = ST_ADDR_ACK;
                                link_d.ack = 1'b1;
                            end else begin
                                link_d.st = ST_IGNORE;
                            end
                        end else begin
                            link_d.st  = ST_DATA_ACK;
                            link_d.ack = 1'b1;
                            link_d.cmd = link_q.shreg;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (fall_i) begin
                        link_d.st     = ST_DATA;
                        link_d.ack    = 1'b0;
                        link_d.bitcnt = '0;
                    end
                end
                ST_DATA_ACK: begin
                    if (rise_i) link_d.fire = 1'b1;
                    if (fall_i) begin
                        link_d.st     = ST_DATA;
                        link_d.ack    = 1'b0;
                        link_d.bitcnt = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_q <= '{st: ST_IDLE, bitcnt: '0, shreg: '0, cmd: '0,
                        ack: 1'b0, fire: 1'b0};
        end else begin
            link_q <= link_d;
        end
    end

    assign ack_o  = link_q.ack;
    assign fire_o = link_q.fire;
    assign cmd_o  = link_q.cmd;

endmodule

// File: rtl/cmdrx_decode.sv
module cmdrx_decode
    import cmdrx_pkg::*;
(
    input  logic                fire_i,
    input  logic [CMD_W-1:0]    cmd_i,
    output logic [NUM_FUNC-1:0] wr_en_o,
    output logic [DATA_W-1:0]   wr_data_o
);

    logic [SEL_W-1:0] sel;
    assign sel = cmd_i[CMD_W-1:DATA_W];

    for (genvar k = 0; k < NUM_FUNC; k++) begin : g_en
        assign wr_en_o[k] = fire_i && (sel == SEL_W'(k));
    end

    always_comb begin
        wr_data_o = (sel == FN_SHUTDOWN) ? '0 : cmd_i[DATA_W-1:0];
    end

endmodule

// File: rtl/i2c_cmd_decoder.sv
module i2c_cmd_decoder
    import cmdrx_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h39,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_pull_o,
    output logic [NUM_FUNC-1:0] wr_en_o,
    output logic [DATA_W-1:0]   wr_data_o
);

    logic [1:0]       sync_vec;
    logic             scl_s, sda_s;
    logic             start_c, stop_c, rise_c, fall_c;
    logic             fire_c;
    logic [CMD_W-1:0] cmd_c;

    cmdrx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (sync_vec)
    );
    assign scl_s = sync_vec[1];
    assign sda_s = sync_vec[0];

    cmdrx_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .start_o (start_c),
        .stop_o  (stop_c),
        .rise_o  (rise_c),
        .fall_o  (fall_c)
    );

    cmdrx_link #(.DEV_ADDR(DEV_ADDR)) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_c),
        .stop_i  (stop_c),
        .rise_i  (rise_c),
        .fall_i  (fall_c),
        .sda_s   (sda_s),
        .ack_o   (sda_pull_o),
        .fire_o  (fire_c),
        .cmd_o   (cmd_c)
    );

    cmdrx_decode u_decode (
        .fire_i    (fire_c),
        .cmd_i     (cmd_c),
        .wr_en_o   (wr_en_o),
        .wr_data_o (wr_data_o)
    );

endmodule

// File: rtl/cmdrx_checker.sv
module cmdrx_checker
    import cmdrx_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                scl_s,
    input logic                sda_pull_o,
    input logic [NUM_FUNC-1:0] wr_en_o,
    input logic [DATA_W-1:0]   wr_data_o
);

    p_onehot_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en_o))
        else $error("write enables not one-hot");

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_en_o) |=> !(|wr_en_o))
        else $error("write enable longer than one cycle");

    p_en_during_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_en_o) |-> sda_pull_o)
        else $error("write enable outside acknowledge");

    p_shutdown_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o[0] |-> (wr_data_o == '0))
        else $error("shutdown carries nonzero value");

    p_ack_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_s)
        else $error("acknowledge asserted while clock high");

endmodule

bind i2c_cmd_decoder cmdrx_checker u_cmdrx_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .sda_pull_o (sda_pull_o),
    .wr_en_o    (wr_en_o),
    .wr_data_o  (wr_data_o)
);

// File: tb/test_i2c_cmd_decoder.sv
module test_i2c_cmd_decoder;

    localparam int Q = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_pull_o;
    logic [7:0] wr_en_o;
    logic [4:0] wr_data_o;
    logic       sda_bus;

    int checks = 0;
    int errors = 0;
    int scnt = 0;
    logic [7:0] last_en = '0;
    logic [4:0] last_data = '0;

    always #5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_pull_o;

    i2c_cmd_decoder i_i2c_cmd_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull_o),
        .wr_en_o    (wr_en_o),
        .wr_data_o  (wr_data_o)
    );

    always @(posedge clk) begin
        if (rst_n && (|wr_en_o)) begin
            scnt      <= scnt + 1;
            last_en   <= wr_en_o;
            last_data <= wr_data_o;
        end
    end

    function automatic logic [7:0] exp_en(input logic [7:0] b);
        return 8'b1 << b[7:5];
    endfunction

    function automatic logic [4:0] exp_data(input logic [7:0] b);
        return (b[7:5] == 3'd0) ? 5'd0 : b[4:0];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(2 * Q);
            m_scl = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        acked = (sda_bus == 1'b0);
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_cmd(input logic [7:0] b, input string req);
        int pre;
        bit ack;
        pre = scnt;
        send_byte(b, ack);
        check(ack, "R4 command ack", ack, 1);
        check(scnt == pre + 1, {req, " one pulse per byte (R7)"}, scnt - pre, 1);
        check(last_en == exp_en(b), {req, " enable select (R5)"}, last_en, exp_en(b));
        check(last_data == exp_data(b), {req, " value field"}, last_data, exp_data(b));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit ack;
        int pre;
        logic [7:0] b;
        void'($urandom(32'd1234));
        tick(4);
        check(sda_pull_o == 1'b0, "R1 reset pull", sda_pull_o, 0);
        check(wr_en_o == '0, "R1 reset enables", wr_en_o, 0);
        rst_n = 1'b1;
        tick(10);

        // R2, R5: one command of each select code
        bus_start();
        send_byte(8'h72, ack);
        check(ack, "R2 address ack", ack, 1);
        for (int s = 0; s < 8; s++) send_cmd({3'(s), 5'h15}, "R5 directed");
        bus_stop();

        // R6: shutdown with all value bits set
        bus_start();
        send_byte(8'h72, ack);
        send_cmd(8'h1F, "R6 shutdown");
        bus_stop();

        // R3: wrong address, then read direction
        for (int v = 0; v < 2; v++) begin
            bus_start();
            send_byte(v == 0 ? 8'h5A : 8'h73, ack);
            check(!ack, "R3 no address ack", ack, 0);
            pre = scnt;
            send_byte(8'h45, ack);
            check(!ack, "R3 ignored byte ack", ack, 0);
            check(scnt == pre, "R3 ignored byte pulse", scnt - pre, 0);
            bus_stop();
        end

        // R9: stop partway through a command byte
        bus_start();
        send_byte(8'h72, ack);
        pre = scnt;
        send_bits(8'h6B, 5);
        bus_stop();
        tick(Q);
        check(scnt == pre, "R9 partial byte before stop", scnt - pre, 0);
        bus_start();
        send_byte(8'h72, ack);
        check(ack, "R9 recovery address ack", ack, 1);
        send_cmd(8'h6B, "R9 recovery");
        bus_stop();

        // R10: repeated start partway through a command byte
        bus_start();
        send_byte(8'h72, ack);
        pre = scnt;
        send_bits(8'hA9, 4);
        bus_start();
        check(scnt == pre, "R10 partial byte before restart", scnt - pre, 0);
        send_byte(8'h72, ack);
        check(ack, "R10 restart address ack", ack, 1);
        send_cmd(8'hC3, "R10 after restart");
        bus_stop();

        // R8: random multi-command frames
        for (int f = 0; f < 14; f++) begin
            bus_start();
            send_byte(8'h72, ack);
            check(ack, "R2 random frame address", ack, 1);
            for (int k = 0; k < 1 + int'($urandom_range(2)); k++) begin
                b = 8'($urandom);
                send_cmd(b, "R8 random");
            end
            bus_stop();
        end

        tick(10);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule